// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This unit keeps the small control and status word that a floating-point pipeline consults on every operation. It holds an 8-bit value made of two fields. The upper field is a 3-bit dynamic rounding mode. The lower field is a set of five sticky exception flags. All bits above these two fields read as zero.

For each operation, the unit works out the rounding mode the arithmetic must use. The instruction supplies a 3-bit mode code. The code 7 means "use the dynamic mode stored in the register"; any other code is used as given. If the resulting mode is not one of the five defined modes, the unit raises an illegal-instruction indication at once, in the same cycle.

When an operation completes with a legal mode, the exception bits it reports are ORed into the sticky field. Only a register write can clear them. A register write and a completing operation may fall in the same cycle. In that case the written value is stored first and the operation's flags are ORed on top of it.

Top module: `fpsr_unit`

## Requirements
- R1: A synchronous active-high reset clears the whole register, so the read value is zero and the dynamic mode is round-to-nearest-even (code 0).
- R2: An instruction mode code of 0 to 4 is passed to the resolved mode unchanged, with the illegal indication low. The codes are: 0 nearest-even, 1 toward zero, 2 downward, 3 upward, 4 nearest with ties away from zero.
- R3: An instruction mode code of 5 or 6 raises the illegal indication in the same cycle.
- R4: An instruction mode code of 7 resolves to the dynamic mode held in register bits 7:5. The illegal indication is raised exactly when that stored mode is 5, 6 or 7.
- R5: A register write stores write-data bits 7:5 as the dynamic mode and bits 4:0 as the sticky flags, taking effect from the next cycle. Read bits XLEN-1:8 are always zero, whatever was written.
- R6: A completing operation with a legal resolved mode ORs its 5-bit flag vector into bits 4:0, never clearing a set bit. The bit positions are inexact 0, underflow 1, overflow 2, divide-by-zero 3, invalid 4.
- R7: A completing operation whose resolved mode is illegal leaves the sticky flags unchanged.
- R8: When a write and a legal completing operation share a cycle, the stored value is the written value with the operation's flags ORed into bits 4:0.
- R9: Without a register write, the dynamic mode field never changes, whatever operations complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_rm | input | 3 | Rounding-mode code from the current instruction |
| op_done | input | 1 | Strobe: an operation completes this cycle |
| op_flags | input | 5 | Exception bits reported by the completing operation |
| csr_we | input | 1 | Register write enable |
| csr_wdata | input | XLEN | Register write data |
| rm_out | output | 3 | Resolved rounding mode |
| rm_illegal | output | 1 | Resolved mode is not a defined mode |
| csr_rdata | output | XLEN | Register read value |

## Verification
The hardest case to reach from the ports is an illegal resolved mode that appears only through indirection. A write must first store an undefined dynamic mode. A later instruction must then carry code 7 while an operation completes, and that operation's flags must be dropped. Directed steps write each of the dynamic modes 5, 6 and 7 and then issue code-7 operations with all flags set. Random writes, which are about one cycle in seven, keep placing undefined dynamic modes under random code-7 traffic. The same write-plus-operation cycles also reach the ordering case of R8.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int RM_W    = 3;
    localparam int FLAG_W  = 5;
    localparam int FIELD_W = RM_W + FLAG_W;
    localparam int RM_MAX_LEGAL = 4;

    typedef enum logic [RM_W-1:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_TO_ZERO   = 3'd1,
        RM_DOWNWARD  = 3'd2,
        RM_UPWARD    = 3'd3,
        RM_NEAR_MAX  = 3'd4,
        RM_RSVD_5    = 3'd5,
        RM_RSVD_6    = 3'd6,
        RM_FROM_REG  = 3'd7
    } rm_code_e;

    // bit 4 .. bit 0
    typedef struct packed {
        logic invalid;
        logic div_zero;
        logic overflow;
        logic underflow;
        logic inexact;
    } fp_flags_t;

    // rounding mode occupies bits 7:5, flags bits 4:0
    typedef struct packed {
        logic [RM_W-1:0] rm;
        fp_flags_t       flags;
    } fpsr_t;

    function automatic logic rm_is_legal(input logic [RM_W-1:0] code);
        return code <= RM_W'(RM_MAX_LEGAL);
    endfunction

    function automatic logic [RM_W-1:0] rm_pick(input logic [RM_W-1:0] insn_code,
                                               input logic [RM_W-1:0] dyn_code);
        return (insn_code == RM_FROM_REG) ? dyn_code : insn_code;
    endfunction

endpackage

// File: rtl/fpsr_rm_resolve.sv
module fpsr_rm_resolve
    import fpsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [RM_W-1:0] insn_rm,
    input  logic [RM_W-1:0] dyn_rm,
    output logic [RM_W-1:0] rm_out,
    output logic            rm_illegal
);

    always_comb begin
        rm_out     = rm_pick(insn_rm, dyn_rm);
        rm_illegal = !rm_is_legal(rm_out);
    end

    AST_RM_PASS: assert property (@(posedge clk) disable iff (rst)
        (insn_rm <= RM_W'(RM_MAX_LEGAL)) |-> (rm_out == insn_rm && !rm_illegal)); // R2

    AST_RM_RSVD: assert property (@(posedge clk) disable iff (rst)
        (insn_rm == RM_RSVD_5 || insn_rm == RM_RSVD_6) |-> rm_illegal); // R3

    AST_RM_DYN: assert property (@(posedge clk) disable iff (rst)
        (insn_rm == RM_FROM_REG) |-> (rm_out == dyn_rm)); // R4

endmodule

// File: rtl/fpsr_flag_acc.sv
module fpsr_flag_acc
    import fpsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fpsr_t             cur,
    input  logic              wr_en,
    input  fpsr_t             wr_val,
    input  logic              op_done,
    input  logic [FLAG_W-1:0] op_flags,
    input  logic              illegal,
    output fpsr_t             nxt
);

    fpsr_t             base;
    logic [FLAG_W-1:0] add_bits;

    always_comb begin
        base      = wr_en ? wr_val : cur;
        add_bits  = (op_done && !illegal) ? op_flags : '0;
        nxt.rm    = base.rm;
        nxt.flags = base.flags | fp_flags_t'(add_bits);
    end

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((cur.flags & $past(cur.flags)) == $past(cur.flags))); // R6

    AST_ILLEGAL_NO_ACC: assert property (@(posedge clk) disable iff (rst)
        (op_done && illegal && !wr_en) |=> (cur.flags == $past(cur.flags))); // R7

    AST_RM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (cur.rm == $past(cur.rm))); // R9

    AST_WRITE_RM: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cur.rm == $past(wr_val.rm))); // R5

endmodule

// File: rtl/fpsr_store.sv
module fpsr_store
    import fpsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fpsr_t d,
    output fpsr_t q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
    import fpsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        insn_rm,
    input  logic              op_done,
    input  logic [4:0]        op_flags,
    input  logic              csr_we,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [2:0]        rm_out,
    output logic              rm_illegal,
    output logic [XLEN-1:0]   csr_rdata
);

    localparam int PAD_W = XLEN - FIELD_W;

    fpsr_t cur_q;
    fpsr_t nxt_d;
    fpsr_t wr_val;

    assign wr_val = fpsr_t'(csr_wdata[FIELD_W-1:0]);

    fpsr_rm_resolve u_resolve (
        .clk        (clk),
        .rst        (rst),
        .insn_rm    (insn_rm),
        .dyn_rm     (cur_q.rm),
        .rm_out     (rm_out),
        .rm_illegal (rm_illegal)
    );

    fpsr_flag_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .cur      (cur_q),
        .wr_en    (csr_we),
        .wr_val   (wr_val),
        .op_done  (op_done),
        .op_flags (op_flags),
        .illegal  (rm_illegal),
        .nxt      (nxt_d)
    );

    fpsr_store u_store (
        .clk (clk),
        .rst (rst),
        .d   (nxt_d),
        .q   (cur_q)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign csr_rdata = {{PAD_W{1'b0}}, cur_q};
        end else begin : g_nopad
            assign csr_rdata = cur_q;
        end
    endgenerate

    AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (csr_we && op_done && !rm_illegal)
        |=> (csr_rdata[FLAG_W-1:0] == ($past(csr_wdata[FLAG_W-1:0]) | $past(op_flags)))); // R8

endmodule

// File: tb/fpsr_unit_bench.sv
module fpsr_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  insn_rm = '0;
    logic        op_done = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [2:0]  rm_out;
    logic        rm_illegal;
    logic [31:0] csr_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [7:0] model = '0;

    always #10 clk = ~clk;

    fpsr_unit #(.XLEN(32)) u_fpsr_unit (
        .clk(clk), .rst(rst), .insn_rm(insn_rm), .op_done(op_done),
        .op_flags(op_flags), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .rm_out(rm_out), .rm_illegal(rm_illegal), .csr_rdata(csr_rdata)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_rm(input logic [2:0] code, input logic [7:0] m);
        return (code == 3'd7) ? m[7:5] : code;
    endfunction

    // called just after a falling edge; returns just after the next falling edge
    task automatic step(input logic [2:0] rm, input logic op, input logic [4:0] fl,
                        input logic we, input logic [31:0] wd);
        logic [2:0] erm;
        logic       eill;
        logic [7:0] base;
        string      tg;
        insn_rm = rm; op_done = op; op_flags = fl; csr_we = we; csr_wdata = wd;
        #1;
        erm  = exp_rm(rm, model);
        eill = erm > 3'd4;
        tg   = (rm == 3'd7) ? "R4" : ((rm > 3'd4) ? "R3" : "R2");
        check(rm_out == erm, tg, {29'd0, rm_out}, {29'd0, erm});
        check(rm_illegal == eill, tg, {31'd0, rm_illegal}, {31'd0, eill});
        base = we ? wd[7:0] : model;
        if (op && !eill) base[4:0] = base[4:0] | fl;
        if (we && op && !eill)      tg = "R8";
        else if (we)                tg = "R5";
        else if (op && eill)        tg = "R7";
        else if (op)                tg = "R6";
        else                        tg = "R9";
        model = base;
        @(posedge clk);
        @(negedge clk);
        check(csr_rdata == {24'd0, model}, tg, csr_rdata, {24'd0, model});
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // reset with write and activity pending: must still clear (R1)
        csr_we = 1'b1; csr_wdata = 32'hFFFF_FFFF; op_done = 1'b1; op_flags = 5'h1F;
        repeat (3) @(negedge clk);
        rst = 1'b0; csr_we = 1'b0; op_done = 1'b0;
        #1;
        check(csr_rdata == 32'd0, "R1", csr_rdata, 32'd0);
        model = '0;
        @(negedge clk);

        // R1: dynamic mode after reset is code 0
        step(3'd7, 1'b0, 5'd0, 1'b0, 32'd0);

        // R2: each defined static code with single-bit flags (R6 positions)
        for (int i = 0; i < 5; i++) step(i[2:0], 1'b1, 5'(1 << i), 1'b0, 32'd0);
        // R6: flags stay set under zero-flag operations
        step(3'd1, 1'b1, 5'd0, 1'b0, 32'd0);

        // R5: write clears flags, upper bits ignored
        step(3'd0, 1'b0, 5'd0, 1'b1, 32'hFFFF_FF60);
        // R3: codes 5 and 6 with all flags
        step(3'd5, 1'b1, 5'h1F, 1'b0, 32'd0);
        step(3'd6, 1'b1, 5'h1F, 1'b0, 32'd0);

        // R4/R7: undefined dynamic modes under code 7
        for (int d = 5; d < 8; d++) begin
            step(3'd0, 1'b0, 5'd0, 1'b1, {24'd0, d[2:0], 5'd0});
            step(3'd7, 1'b1, 5'h1F, 1'b0, 32'd0);
        end
        // R4: defined dynamic mode under code 7 accumulates
        step(3'd0, 1'b0, 5'd0, 1'b1, {24'd0, 3'd3, 5'd0});
        step(3'd7, 1'b1, 5'h0A, 1'b0, 32'd0);

        // R8: write and operation in the same cycle
        step(3'd2, 1'b1, 5'h11, 1'b1, 32'h0000_0086);
        // R8 with illegal code: only the written value lands
        step(3'd6, 1'b1, 5'h1F, 1'b1, 32'h0000_0040);
        // R9: many operations, mode field untouched
        for (int i = 0; i < 4; i++) step(3'(i), 1'b1, 5'(i + 3), 1'b0, 32'd0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [2:0]  r_rm;
            logic        r_op;
            logic [4:0]  r_fl;
            logic        r_we;
            logic [31:0] r_wd;
            r_rm = 3'($urandom);
            r_op = ($urandom % 2) == 0;
            r_fl = ($urandom % 4 == 0) ? 5'(1 << ($urandom % 5)) : 5'($urandom);
            r_we = ($urandom % 7) == 0;
            r_wd = $urandom;
            if ($urandom % 3 == 0) r_wd[4:0] = 5'd0;
            step(r_rm, r_op, r_fl, r_we, r_wd);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule